// File: doc/BRIEF.md
# Chainable Nine-Bit FIFO with Occupancy Flags

This block is a first-in first-out buffer for nine-bit words. A parameter sets its depth to 256, 512, 1024, 2048 or 4096 words. Words are kept in a dual-port store. The write pointer and the read pointer move independently, so a push and a pop can complete in the same clock cycle. Three active-low flags report the fill level: empty, more-than-half full, and full. A synchronous, active-low master clear returns the buffer to an empty state, but only while both access strobes are idle. A clear requested while a strobe is active is refused, and the refusal is reported.

All inputs are sampled on one system clock. The active-low write and read strobes each request one access per cycle in which they are low. The read data port is modelled as a data bus plus an output-enable. The enable is raised only in the cycle that follows an accepted read, and it stands in for a bus that is otherwise high-impedance.

Several instances can be joined into one deeper queue. To do this, connect each instance's token output pair to the next instance's token input pair, and close the ring. One instance is marked as the first-load device. An instance accepts writes only while it holds the write token, and reads only while it holds the read token. When it uses its last physical location, it passes the token on with a one-cycle pulse.

Top module: `chained_fifo9`

## Requirements
- R1: Words leave the buffer in the order they were written, and all nine data bits are kept unchanged.
- R2: When a write and a read are both accepted in one cycle, both take effect: the read returns the oldest word, and the new word is stored behind the ones already held.
- R3: A master clear (clr_n low) while wr_n and rd_n are both high empties the buffer. From the following cycle, empty_n is low, half_n is high, full_n is high and reset_err is low.
- R4: A master clear while wr_n or rd_n is low is refused. From the following cycle reset_err is high and stays high until a valid clear. The stored words and the flags are unchanged, and no access takes place.
- R5: dout_oe is high, and dout carries the word read, only in the cycle right after an accepted read. A read requested while the buffer is empty, including right after a clear, leaves dout_oe low.
- R6: half_n is low exactly while the number of stored words is greater than DEPTH/2. It returns high once the count is DEPTH/2 or less.
- R7: full_n is low exactly while the count equals DEPTH. A write requested while full is ignored and does not overwrite any stored word.
- R8: empty_n is low exactly while the count is zero. A read requested while empty is ignored.
- R9: With chaining enabled, an instance accepts writes only while it holds the write token. An accepted write to physical location DEPTH-1 gives up that token and pulses tok_out[0] high for exactly one cycle.
- R10: With chaining enabled, an accepted read from physical location DEPTH-1 gives up the read token and pulses tok_out[1] high for exactly one cycle.
- R11: A high level on tok_in[0] (write) or tok_in[1] (read) gives the instance that token from the next cycle. After a valid clear, the instance with FIRST_LOAD=1 holds both tokens and the others hold none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| clr_n | input | 1 | Synchronous master clear, active low |
| wr_n | input | 1 | Write strobe, active low, one word per cycle |
| rd_n | input | 1 | Read strobe, active low, one word per cycle |
| din | input | WIDTH | Word to store |
| dout | output | WIDTH | Word read, valid while dout_oe is high |
| dout_oe | output | 1 | Output enable; low stands for a high-impedance bus |
| empty_n | output | 1 | Low while no word is stored |
| half_n | output | 1 | Low while more than DEPTH/2 words are stored |
| full_n | output | 1 | Low while DEPTH words are stored |
| reset_err | output | 1 | High after a refused master clear |
| tok_in | input | 2 | Token pulses from the previous instance: bit 0 write, bit 1 read |
| tok_out | output | 2 | Token pulses to the next instance: bit 0 write, bit 1 read |

## Verification
The properties assume the strobes and clr_n are clean levels that change once per cycle, away from the rising edge. They also assume a token pulse arrives only at an instance that is waiting for that token, so no instance ever holds a token twice. The bench drives every input on the falling edge and holds it for one full cycle. In the chained test it wires the two instances into a ring, and it keeps the shared strobes idle for one cycle after each handoff pulse, so that no access is requested while neither instance holds the token.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

    // Kind of master clear seen in a cycle.
    typedef enum logic [1:0] {
        CLR_NONE = 2'd0,
        CLR_GOOD = 2'd1,
        CLR_BAD  = 2'd2
    } clr_kind_e;

    // Token bit positions on tok_in / tok_out.
    localparam int TOK_WR = 0;
    localparam int TOK_RD = 1;

endpackage

// File: rtl/fifo9_store.sv
module fifo9_store #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/fifo9_flags.sv
module fifo9_flags #(
    parameter int DEPTH = 256,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] count,
    output logic          empty_n,
    output logic          half_n,
    output logic          full_n
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    always_comb begin
        empty_n = (count != '0);
        half_n  = !(count > HALF_CNT);
        full_n  = (count != FULL_CNT);
    end

endmodule

// File: rtl/fifo9_token.sv
module fifo9_token
    import fifo9_pkg::*;
#(
    parameter bit CHAIN_EN   = 1'b0,
    parameter bit FIRST_LOAD = 1'b1
) (
    input  logic       clk,
    input  logic       clr_good,
    input  logic       hold,
    input  logic       wr_last,
    input  logic       rd_last,
    input  logic [1:0] tok_in,
    output logic       wr_tok,
    output logic       rd_tok,
    output logic [1:0] tok_out
);

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] pulse;
    } tok_t;

    tok_t tok_d, tok_q;

    always_comb begin
        tok_d = tok_q;
        if (clr_good) begin
            tok_d.wr    = FIRST_LOAD;
            tok_d.rd    = FIRST_LOAD;
            tok_d.pulse = 2'b00;
        end else if (hold) begin
            tok_d.pulse = 2'b00;
        end else begin
            tok_d.pulse[TOK_WR] = wr_last;
            tok_d.pulse[TOK_RD] = rd_last;
            tok_d.wr = (tok_q.wr && !wr_last) || tok_in[TOK_WR];
            tok_d.rd = (tok_q.rd && !rd_last) || tok_in[TOK_RD];
        end
    end

    always_ff @(posedge clk) begin
        tok_q <= tok_d;
    end

    // Without chaining the instance always owns both rights and never hands off.
    generate
        if (CHAIN_EN) begin : g_chain
            assign wr_tok  = tok_q.wr;
            assign rd_tok  = tok_q.rd;
            assign tok_out = tok_q.pulse;
        end else begin : g_solo
            assign wr_tok  = 1'b1 | tok_q.wr;
            assign rd_tok  = 1'b1 | tok_q.rd;
            assign tok_out = tok_q.pulse & 2'b00;
        end
    endgenerate

endmodule

// File: rtl/chained_fifo9.sv
module chained_fifo9
    import fifo9_pkg::*;
#(
    parameter int WIDTH      = 9,
    parameter int DEPTH      = 256,
    parameter bit CHAIN_EN   = 1'b0,
    parameter bit FIRST_LOAD = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             half_n,
    output logic             full_n,
    output logic             reset_err,
    input  logic [1:0]       tok_in,
    output logic [1:0]       tok_out
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          oe;
        logic          err;
    } ctl_t;

    ctl_t      ctl_d, ctl_q;
    clr_kind_e clr_kind;
    logic      wr_tok, rd_tok;
    logic      wr_ok, rd_ok;
    logic      wr_last, rd_last;

    always_comb begin
        clr_kind = CLR_NONE;
        if (!clr_n) begin
            clr_kind = (wr_n && rd_n) ? CLR_GOOD : CLR_BAD;
        end

        wr_ok   = clr_n && !wr_n && wr_tok && (ctl_q.cnt != FULL_CNT);
        rd_ok   = clr_n && !rd_n && rd_tok && (ctl_q.cnt != '0);
        wr_last = wr_ok && (ctl_q.wp == LAST_LOC);
        rd_last = rd_ok && (ctl_q.rp == LAST_LOC);

        ctl_d = ctl_q;
        unique case (clr_kind)
            CLR_GOOD: begin
                ctl_d = '0;
            end
            CLR_BAD: begin
                ctl_d.err = 1'b1;
                ctl_d.oe  = 1'b0;
            end
            default: begin
                if (wr_ok) begin
                    ctl_d.wp = ctl_q.wp + 1'b1;
                end
                if (rd_ok) begin
                    ctl_d.rp = ctl_q.rp + 1'b1;
                end
                ctl_d.cnt = ctl_q.cnt + CW'(wr_ok) - CW'(rd_ok);
                ctl_d.oe  = rd_ok;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    fifo9_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (ctl_q.wp),
        .wdata (din),
        .re    (rd_ok),
        .raddr (ctl_q.rp),
        .rdata (dout)
    );

    fifo9_flags #(
        .DEPTH (DEPTH)
    ) u_flags (
        .count   (ctl_q.cnt),
        .empty_n (empty_n),
        .half_n  (half_n),
        .full_n  (full_n)
    );

    fifo9_token #(
        .CHAIN_EN   (CHAIN_EN),
        .FIRST_LOAD (FIRST_LOAD)
    ) u_token (
        .clk      (clk),
        .clr_good (clr_kind == CLR_GOOD),
        .hold     (clr_kind == CLR_BAD),
        .wr_last  (wr_last),
        .rd_last  (rd_last),
        .tok_in   (tok_in),
        .wr_tok   (wr_tok),
        .rd_tok   (rd_tok),
        .tok_out  (tok_out)
    );

    assign dout_oe   = ctl_q.oe;
    assign reset_err = ctl_q.err;

endmodule

// File: rtl/fifo9_chk.sv
module fifo9_chk #(
    parameter bit CHAIN_EN = 1'b0
) (
    input logic       clk,
    input logic       clr_n,
    input logic       wr_n,
    input logic       rd_n,
    input logic       dout_oe,
    input logic       empty_n,
    input logic       half_n,
    input logic       full_n,
    input logic       reset_err,
    input logic [1:0] tok_in,
    input logic [1:0] tok_out,
    input logic       wr_tok,
    input logic       rd_tok
);

    assert_clear_state_R3: assert property (@(posedge clk)
        (!clr_n && wr_n && rd_n) |=> (!empty_n && half_n && full_n && !reset_err));

    assert_bad_clear_R4: assert property (@(posedge clk)
        (!clr_n && (!wr_n || !rd_n)) |=> (reset_err && $stable({empty_n, half_n, full_n})));

    assert_idle_no_oe_R5: assert property (@(posedge clk) disable iff (!clr_n)
        rd_n |=> !dout_oe);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!clr_n)
        (!full_n && rd_n) |=> !full_n);

    assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!clr_n)
        (!empty_n && wr_n) |=> (!empty_n && !dout_oe));

    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!clr_n)
        tok_out[0] |=> !tok_out[0]);

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!clr_n)
        tok_out[1] |=> !tok_out[1]);

    assert_take_wr_R11: assert property (@(posedge clk) disable iff (!clr_n)
        (CHAIN_EN && tok_in[0]) |=> wr_tok);

    assert_take_rd_R11: assert property (@(posedge clk) disable iff (!clr_n)
        (CHAIN_EN && tok_in[1]) |=> rd_tok);

endmodule

bind chained_fifo9 fifo9_chk #(
    .CHAIN_EN (CHAIN_EN)
) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .dout_oe   (dout_oe),
    .empty_n   (empty_n),
    .half_n    (half_n),
    .full_n    (full_n),
    .reset_err (reset_err),
    .tok_in    (tok_in),
    .tok_out   (tok_out),
    .wr_tok    (wr_tok),
    .rd_tok    (rd_tok)
);

// File: tb/tb_chained_fifo9.sv
`timescale 1ns/1ps
module tb_chained_fifo9;

    localparam int DEPTH = 256;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // Single instance without chaining.
    logic       clr_n, wr_n, rd_n;
    logic [8:0] din, dout;
    logic       dout_oe, empty_n, half_n, full_n, reset_err;
    logic [1:0] tok_out;

    chained_fifo9 #(.DEPTH(DEPTH)) dut (
        .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .rd_n(rd_n), .din(din),
        .dout(dout), .dout_oe(dout_oe), .empty_n(empty_n), .half_n(half_n),
        .full_n(full_n), .reset_err(reset_err), .tok_in(2'b00), .tok_out(tok_out)
    );

    // Two chained instances in a ring sharing strobes and data.
    logic       c_clr_n, c_wr_n, c_rd_n;
    logic [8:0] c_din, a_dout, b_dout;
    logic       a_oe, b_oe, a_e, b_e, a_h, b_h, a_f, b_f, a_err, b_err;
    logic [1:0] a_xo, b_xo;

    chained_fifo9 #(.DEPTH(DEPTH), .CHAIN_EN(1'b1), .FIRST_LOAD(1'b1)) dev_a (
        .clk(clk), .clr_n(c_clr_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
        .dout(a_dout), .dout_oe(a_oe), .empty_n(a_e), .half_n(a_h),
        .full_n(a_f), .reset_err(a_err), .tok_in(b_xo), .tok_out(a_xo)
    );

    chained_fifo9 #(.DEPTH(DEPTH), .CHAIN_EN(1'b1), .FIRST_LOAD(1'b0)) dev_b (
        .clk(clk), .clr_n(c_clr_n), .wr_n(c_wr_n), .rd_n(c_rd_n), .din(c_din),
        .dout(b_dout), .dout_oe(b_oe), .empty_n(b_e), .half_n(b_h),
        .full_n(b_f), .reset_err(b_err), .tok_in(a_xo), .tok_out(b_xo)
    );

    wire [8:0] c_bus = a_oe ? a_dout : b_dout;
    wire       c_oe  = a_oe | b_oe;

    typedef struct packed {
        logic       w;
        logic       r;
        logic [8:0] d;
        logic       exp_e;
        logic       exp_oe;
        logic [8:0] exp_q;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 1'b0, 9'h101, 1'b1, 1'b0, 9'h000},
        '{1'b1, 1'b0, 9'h0A5, 1'b1, 1'b0, 9'h000},
        '{1'b0, 1'b1, 9'h000, 1'b1, 1'b1, 9'h101},
        '{1'b1, 1'b1, 9'h1FF, 1'b1, 1'b1, 9'h0A5},
        '{1'b0, 1'b1, 9'h000, 1'b0, 1'b1, 9'h1FF},
        '{1'b0, 1'b1, 9'h000, 1'b0, 1'b0, 9'h000},
        '{1'b1, 1'b0, 9'h000, 1'b1, 1'b0, 9'h000},
        '{1'b0, 1'b1, 9'h000, 1'b0, 1'b1, 9'h000}
    };

    function automatic logic [8:0] pat(input int i);
        return 9'((i * 37 + 5) % 512);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle on the single instance; returns at the next falling edge.
    task automatic step(input logic w, input logic r, input logic [8:0] d);
        wr_n = !w;
        rd_n = !r;
        din  = d;
        @(negedge clk);
    endtask

    task automatic cstep(input logic w, input logic r, input logic [8:0] d);
        c_wr_n = !w;
        c_rd_n = !r;
        c_din  = d;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            finish_run();
        end
    end

    initial begin
        clr_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; din = '0;
        c_clr_n = 1'b0; c_wr_n = 1'b1; c_rd_n = 1'b1; c_din = '0;
        @(negedge clk);
        @(negedge clk);
        clr_n = 1'b1;
        c_clr_n = 1'b1;

        // R3: state after a valid clear
        chk("R3 empty_n", int'(empty_n), 0);
        chk("R3 half_n", int'(half_n), 1);
        chk("R3 full_n", int'(full_n), 1);
        chk("R3 reset_err", int'(reset_err), 0);
        // R5: read right after clear yields nothing
        step(1'b0, 1'b1, '0);
        chk("R5 oe after clear read", int'(dout_oe), 0);

        // R1 R2 R5 R8: vector table
        foreach (VEC[i]) begin
            step(VEC[i].w, VEC[i].r, VEC[i].d);
            chk($sformatf("R8 vec%0d empty_n", i), int'(empty_n), int'(VEC[i].exp_e));
            chk($sformatf("R5 vec%0d oe", i), int'(dout_oe), int'(VEC[i].exp_oe));
            if (VEC[i].exp_oe)
                chk($sformatf("R1 R2 vec%0d dout", i), int'(dout), int'(VEC[i].exp_q));
        end

        // R6 R7: fill to the top
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, pat(i));
            if (i == DEPTH / 2 - 1) chk("R6 half_n at half", int'(half_n), 1);
            if (i == DEPTH / 2)     chk("R6 half_n above half", int'(half_n), 0);
            if (i == DEPTH - 2)     chk("R7 full_n one short", int'(full_n), 1);
        end
        chk("R7 full_n at depth", int'(full_n), 0);
        step(1'b1, 1'b0, 9'h1AA);
        chk("R7 full_n after extra write", int'(full_n), 0);

        // R1 R6 R7 R8: drain and verify order, no overwrite
        for (int j = 1; j <= DEPTH; j++) begin
            step(1'b0, 1'b1, '0);
            chk($sformatf("R1 R7 word%0d", j - 1), int'(dout), int'(pat(j - 1)));
            if (j == DEPTH / 2 - 1) chk("R6 half_n count half+1", int'(half_n), 0);
            if (j == DEPTH / 2)     chk("R6 half_n back at half", int'(half_n), 1);
            if (j == DEPTH - 1)     chk("R8 empty_n one left", int'(empty_n), 1);
        end
        chk("R8 empty_n drained", int'(empty_n), 0);
        step(1'b0, 1'b1, '0);
        chk("R8 read when empty oe", int'(dout_oe), 0);

        // R4: refused clear
        step(1'b1, 1'b0, 9'h011);
        step(1'b1, 1'b0, 9'h022);
        clr_n = 1'b0;
        step(1'b1, 1'b0, 9'h033);
        chk("R4 reset_err", int'(reset_err), 1);
        chk("R4 empty_n kept", int'(empty_n), 1);
        clr_n = 1'b1;
        step(1'b0, 1'b1, '0);
        chk("R4 err held", int'(reset_err), 1);
        chk("R4 first word kept", int'(dout), 9'h011);
        step(1'b0, 1'b1, '0);
        chk("R4 no write in bad clear", int'(dout), 9'h022);
        chk("R4 empty after two", int'(empty_n), 0);
        clr_n = 1'b0;
        step(1'b0, 1'b0, '0);
        clr_n = 1'b1;
        chk("R3 err cleared", int'(reset_err), 0);

        // R9 R11: chained writes
        cstep(1'b1, 1'b0, pat(0));
        chk("R11 b holds no write token", int'(b_e), 0);
        chk("R11 a took first word", int'(a_e), 1);
        for (int i = 1; i < DEPTH; i++) begin
            cstep(1'b1, 1'b0, pat(i));
            if (i == DEPTH - 2) chk("R9 no early pulse", int'(a_xo[0]), 0);
        end
        chk("R9 write pulse", int'(a_xo[0]), 1);
        cstep(1'b0, 1'b0, '0);
        chk("R9 pulse one cycle", int'(a_xo[0]), 0);
        cstep(1'b1, 1'b0, pat(DEPTH));
        cstep(1'b1, 1'b0, pat(DEPTH + 1));
        chk("R11 b took word", int'(b_e), 1);
        chk("R9 a still full", int'(a_f), 0);

        // R10 R11: chained reads
        for (int j = 0; j < DEPTH; j++) begin
            cstep(1'b0, 1'b1, '0);
            if (j == 0 || j == DEPTH - 1) begin
                chk("R10 oe from a", int'(a_oe), 1);
                chk("R1 chain word a", int'(c_bus), int'(pat(j)));
            end
        end
        chk("R10 read pulse", int'(a_xo[1]), 1);
        cstep(1'b0, 1'b0, '0);
        chk("R10 read pulse one cycle", int'(a_xo[1]), 0);
        cstep(1'b0, 1'b1, '0);
        chk("R11 oe from b", int'(b_oe), 1);
        chk("R1 chain word b", int'(c_bus), int'(pat(DEPTH)));
        cstep(1'b0, 1'b1, '0);
        chk("R1 chain word b2", int'(c_bus), int'(pat(DEPTH + 1)));
        chk("R8 b drained", int'(b_e), 0);
        cstep(1'b0, 1'b1, '0);
        chk("R8 chain empty read", int'(c_oe), 0);

        finish_run();
    end

endmodule